// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit

This block moves an N-bit word left or right, either as a logical shift (vacated positions take zeros) or as a rotation (the bit that leaves one end comes back in at the other end). The bit pattern moves by one position per clock cycle. The run time therefore grows with the requested distance. A single `start` pulse captures the operand, the distance and the operation. The unit then steps a bidirectional register. A step counter, advanced by a ripple incrementer built from adder cells, records how many single-position moves are complete. When the count reaches the requested distance, `finished` goes high and `result` holds the answer.

The distance input is one bit wider than log2(N), so a distance of N or more can be requested. A logical shift by such a distance leaves an all-zero word. A rotation by such a distance wraps past a full turn. The unit has no sign-extending right shift.

Top module: `shr_iter_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted start, `result` is zero and `finished` is low.
- R2: With `mode` = 2'b00 (bit 1 = 0 for left, bit 0 = 0 for shift), `result` equals the captured word shifted toward the MSB by `amount` positions, with zeros entering at bit 0.
- R3: With `mode` = 2'b10 (right, shift), the word moves toward the LSB and zeros enter at bit N-1 even when the MSB was set, so no sign extension occurs.
- R4: With `mode` = 2'b01 (left, rotate), the bit leaving bit N-1 re-enters at bit 0 on each step.
- R5: With `mode` = 2'b11 (right, rotate), the bit leaving bit 0 re-enters at bit N-1 on each step.
- R6: For a requested distance A, `finished` first reads high after the (A+1)-th rising edge that follows the edge that sampled `start`.
- R7: A distance of zero raises `finished` after one rising edge following the accepting edge, with `result` equal to the captured word, in every mode.
- R8: The edge that accepts `start` drives `finished` low. Once `finished` is high, it and `result` stay unchanged until the next start.
- R9: A shift by N or more yields zero. A rotation by A at or above N yields the same word as a rotation by A mod N.
- R10: A `start` pulse that arrives while an operation is running is ignored and does not alter that operation's result or timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Single-cycle request; captures data_in, amount and mode |
| data_in | input | N | Word to be moved |
| amount | input | $clog2(N)+1 | Number of single-position steps |
| mode | input | 2 | Bit 1: 0 left, 1 right. Bit 0: 0 shift, 1 rotate |
| result | output | N | Working register; the answer while finished is high |
| finished | output | 1 | High from completion until the next accepted start |

## Verification
The assertions assume that reset is applied before the first start. They also assume that `amount` and `mode` matter only in the cycle that `start` is sampled. The bench drives every input one nanosecond after a rising edge and holds it for the whole cycle. It waits for each operation to complete before it issues the next one. The one exception is a deliberate start pulse during a running operation, and the bench leaves that pulse out of the expected-result queue.

// File: rtl/shr_pkg.sv
package shr_pkg;

  // bit 1 selects direction (1 = toward LSB), bit 0 selects rotate
  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_ROL = 2'b01,
    OP_SHR = 2'b10,
    OP_ROR = 2'b11
  } shr_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_DONE = 2'b10
  } shr_state_e;

  function automatic logic op_is_right(input shr_op_e op);
    return op[1];
  endfunction

  function automatic logic op_is_rotate(input shr_op_e op);
    return op[0];
  endfunction

endpackage

// File: rtl/shr_step_cnt.sv
module shr_step_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         adv,
  output logic [W-1:0] cnt
);

  // one full-adder cell, b tied low by the caller
  function automatic logic [1:0] full_add(input logic a, input logic b, input logic ci);
    logic s, co;
    s  = a ^ b ^ ci;
    co = (a & b) | (a & ci) | (b & ci);
    return {co, s};
  endfunction

  // ripple incrementer: a chain of full adders with carry-in 1
  function automatic logic [W-1:0] ripple_inc(input logic [W-1:0] a);
    logic [W-1:0] r;
    logic         c;
    logic [1:0]   fa;
    c = 1'b1;
    for (int i = 0; i < W; i++) begin
      fa   = full_add(a[i], 1'b0, c);
      r[i] = fa[0];
      c    = fa[1];
    end
    return r;
  endfunction

  logic [W-1:0] cnt_plus1;
  assign cnt_plus1 = ripple_inc(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (adv)   cnt <= cnt_plus1;
  end

  p_count_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clear) |=> (cnt == $past(cnt) + W'(1)))
    else $error("step counter did not advance by one");

  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0))
    else $error("step counter not cleared");

endmodule

// File: rtl/shr_step_reg.sv
module shr_step_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         step,
  input  logic         to_right,
  input  logic         rotate,
  output logic [N-1:0] q
);

  logic [N-1:0] up_next;   // toward MSB
  logic [N-1:0] dn_next;   // toward LSB
  logic         wrap_lo;   // value entering bit 0 on a left step
  logic         wrap_hi;   // value entering bit N-1 on a right step

  assign wrap_lo = rotate & q[N-1];
  assign wrap_hi = rotate & q[0];

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == 0) begin : g_lo
      assign up_next[i] = wrap_lo;
    end else begin : g_lo_n
      assign up_next[i] = q[i-1];
    end
    if (i == N-1) begin : g_hi
      assign dn_next[i] = wrap_hi;
    end else begin : g_hi_n
      assign dn_next[i] = q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= to_right ? dn_next : up_next;
  end

  p_fill_left_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !rotate && !to_right) |=> (q[0] == 1'b0))
    else $error("left shift did not fill with zero");

  p_fill_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !rotate && to_right) |=> (q[N-1] == 1'b0))
    else $error("right shift extended a bit into the MSB");

  p_rot_left_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && rotate && !to_right) |=> (q[0] == $past(q[N-1])))
    else $error("left rotation lost the MSB");

  p_rot_right_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && rotate && to_right) |=> (q[N-1] == $past(q[0])))
    else $error("right rotation lost the LSB");

  p_rot_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && rotate) |=> ($countones(q) == $countones($past(q))))
    else $error("rotation changed the population count");

endmodule

// File: rtl/shr_seq_ctrl.sv
module shr_seq_ctrl
  import shr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] amount,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] cnt,
  output logic          accept,
  output logic          step,
  output logic          to_right,
  output logic          rotate,
  output logic          finished
);

  shr_state_e    state;
  logic [AW-1:0] target;
  shr_op_e       op_q;
  logic          at_goal;
  logic          running;

  assign running  = (state == ST_RUN);
  assign at_goal  = (cnt == target);
  assign accept   = start && !running;
  assign step     = running && !at_goal;
  assign to_right = op_is_right(op_q);
  assign rotate   = op_is_rotate(op_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      target   <= '0;
      op_q     <= OP_SHL;
      finished <= 1'b0;
    end else if (accept) begin
      state    <= ST_RUN;
      target   <= amount;
      op_q     <= shr_op_e'(mode);
      finished <= 1'b0;
    end else if (running && at_goal) begin
      state    <= ST_DONE;
      finished <= 1'b1;
    end
  end

  p_hold_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !start) |=> finished)
    else $error("finished dropped without a new start");

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !finished)
    else $error("finished still high after an accepted start");

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= target))
    else $error("step count ran past the requested distance");

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start) |=> ($stable(target) && $stable(op_q)))
    else $error("start during a run altered the operation");

  p_no_step_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !step)
    else $error("register stepped after completion");

endmodule

// File: rtl/shr_iter_unit.sv
module shr_iter_unit #(
  parameter int N  = 8,
  parameter int AW = $clog2(N) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [N-1:0]  data_in,
  input  logic [AW-1:0] amount,
  input  logic [1:0]    mode,
  output logic [N-1:0]  result,
  output logic          finished
);

  logic          accept;
  logic          step;
  logic          to_right;
  logic          rotate;
  logic [AW-1:0] cnt;

  shr_seq_ctrl #(.AW(AW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .amount   (amount),
    .mode     (mode),
    .cnt      (cnt),
    .accept   (accept),
    .step     (step),
    .to_right (to_right),
    .rotate   (rotate),
    .finished (finished)
  );

  shr_step_cnt #(.W(AW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .adv   (step),
    .cnt   (cnt)
  );

  shr_step_reg #(.N(N)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (data_in),
    .step     (step),
    .to_right (to_right),
    .rotate   (rotate),
    .q        (result)
  );

  p_stable_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (finished && !start) |=> $stable(result))
    else $error("result moved after completion");

endmodule

// File: tb/test_shr_iter_unit.sv
module test_shr_iter_unit;
  localparam int N  = 8;
  localparam int AW = $clog2(N) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  data_in = '0;
  logic [AW-1:0] amount = '0;
  logic [1:0]    mode = 2'b00;
  logic [N-1:0]  result;
  logic          finished;

  always #2 clk = ~clk;

  shr_iter_unit #(.N(N)) i_shr_iter_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
    .amount(amount), .mode(mode), .result(result), .finished(finished)
  );

  typedef struct {
    logic [N-1:0] res;
    int           lat;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   errs = 0;
  int   checks = 0;
  bit   pending = 0;
  int   cyc = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // reference: plain operators, independent of the stepping hardware
  function automatic logic [N-1:0] model(input logic [N-1:0] d, input int a, input logic [1:0] m);
    logic [2*N-1:0] t;
    int r;
    if (!m[0]) begin
      if (a >= N) return '0;
      return m[1] ? (d >> a) : (d << a);
    end
    r = a % N;
    if (!m[1]) begin
      t = {d, d} << r;
      return t[2*N-1:N];
    end
    t = {d, d} >> r;
    return t[N-1:0];
  endfunction

  task automatic run_op(input logic [N-1:0] d, input int a, input logic [1:0] m, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.res = model(d, a, m);
    e.lat = a + 2;
    e.tag = tag;
    exp_q.push_back(e);
    start = 1'b1; data_in = d; amount = AW'(a); mode = m;
    @(posedge clk); #1;
    start = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  // monitor: measures latency and compares results at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (start && !pending) begin
          pending = 1;
          cyc = 0;
        end else if (pending) begin
          cyc++;
          if (cyc == 1) chk(finished == 1'b0, "R8 start clears finished", int'(finished), 0);
          if (finished) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(result == e.res, {e.tag, " result"}, int'(result), int'(e.res));
            chk(cyc == e.lat, "R6 latency", cyc, e.lat);
            pending = 0;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result == '0 && !finished, "R1 reset state", int'({finished, result}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(result == '0 && !finished, "R1 idle after reset", int'({finished, result}), 0);

    run_op(8'hB5, 3, 2'b00, "R2 shl");
    run_op(8'h01, 7, 2'b00, "R2 shl to msb");
    run_op(8'h96, 1, 2'b10, "R3 shr msb set");
    run_op(8'h80, 7, 2'b10, "R3 shr no sign ext");
    run_op(8'h81, 1, 2'b01, "R4 rol wrap");
    run_op(8'hA7, 5, 2'b01, "R4 rol");
    run_op(8'h01, 1, 2'b11, "R5 ror wrap");
    run_op(8'h3C, 6, 2'b11, "R5 ror");
    for (int m = 0; m < 4; m++) run_op(8'h5A, 0, 2'(m), "R7 zero amount");
    run_op(8'hFF, 8, 2'b00, "R9 shl by N");
    run_op(8'hFF, 15, 2'b10, "R9 shr by 2N-1");
    run_op(8'hC3, 11, 2'b01, "R9 rol past N");
    run_op(8'hC3, 9, 2'b11, "R9 ror past N");

    // R8: completion state holds while no new start arrives
    begin
      logic [N-1:0] held;
      held = result;
      repeat (5) @(negedge clk);
      chk(finished == 1'b1, "R8 finished holds", int'(finished), 1);
      chk(result == held, "R8 result holds", int'(result), int'(held));
    end

    // R10: a second start mid-run is not queued and must change nothing
    begin
      exp_t e;
      @(posedge clk); #1;
      e.res = model(8'h6D, 6, 2'b01); e.lat = 8; e.tag = "R10 busy start ignored";
      exp_q.push_back(e);
      start = 1'b1; data_in = 8'h6D; amount = AW'(6); mode = 2'b01;
      @(posedge clk); #1 start = 1'b0;
      repeat (2) @(posedge clk);
      #1 start = 1'b1; data_in = 8'h12; amount = AW'(1); mode = 2'b10;
      @(posedge clk); #1 start = 1'b0; data_in = '0;
      wait (exp_q.size() == 0);
      @(negedge clk);
    end

    for (int k = 0; k < 24; k++) begin
      logic [N-1:0] d;
      int a;
      logic [1:0] m;
      d = N'($urandom);
      a = $urandom_range(0, 2*N-1);
      m = 2'($urandom);
      run_op(d, a, m, m[0] ? "R4 R5 R9 mixed rotate" : "R2 R3 R9 mixed shift");
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule